// File: doc/BRIEF.md
# Charge-Pump Wake-Up Sequencer

This block orders the start-up of a fractional synthesizer loop that has two charge pumps driving the loop filter. One is the main pump. The other is an auxiliary pump whose current opposes the main pump.

When the standby request is withdrawn, the sequencer turns the main pump on and keeps the auxiliary pump switched off. For a programmed number of reference-clock cycles, the full main-pump current therefore charges the filter alone. This drives the control voltage toward lock much faster than the net current of both pumps would. When the interval runs out, the auxiliary pump is released and a done flag is raised.

The interval is set so that the auxiliary pump comes on before the output frequency first crosses its target, with margin to spare. A typical setting is about one microsecond, for example 25 cycles of a 25 MHz reference. This keeps total settling within a few microseconds.

The standby request may arrive from any clock domain. It is resynchronized to the reference clock before use. Raising standby at any moment returns both pumps to the off condition and clears the interval count, so the next wake-up replays the whole sequence.

Top module: `cp_wake_sequencer`

## Requirements
- R1: While `rst_n` is low, and after reset until a wake-up completes its synchronization, `main_pump_en` is 0, `aux_pump_off` is 1 and `settle_done` is 0.
- R2: `standby_a` passes through two reference-clock flops. A low level first sampled at edge k raises `main_pump_en` after edge k+2. A high level first sampled at edge k turns the pumps off after edge k+1.
- R3: Whenever the auxiliary pump is on (`aux_pump_off` = 0), the main pump is also on. In the boost phase with N > 0, `main_pump_en` is 1 while `aux_pump_off` stays 1.
- R4: With a captured count N > 0, `aux_pump_off` falls exactly N clock edges after the edge that raised `main_pump_en`.
- R5: A captured count of 0 turns on both pumps at the same edge: `main_pump_en` rises and `aux_pump_off` falls together.
- R6: `settle_done` rises at the same edge at which `aux_pump_off` falls. It stays 1 until standby is reasserted, and is 1 only while both pumps are on.
- R7: Reasserting standby at any point, including mid-interval, drives `main_pump_en` to 0, `aux_pump_off` to 1 and `settle_done` to 0, and clears the interval count. The next wake-up runs the full N-cycle interval.
- R8: `delay_count` is captured at the edge that raises `main_pump_en`. Later changes have no effect on the sequence in progress.
- R9: The full-scale count 2^CNT_W-1 produces an interval of exactly that many cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the interval is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_a | input | 1 | Standby request, asynchronous; high holds the loop idle |
| delay_count | input | CNT_W | Boost-interval length in reference cycles |
| main_pump_en | output | 1 | High enables the main charge pump |
| aux_pump_off | output | 1 | High holds the opposing auxiliary pump off |
| settle_done | output | 1 | High once the auxiliary pump has been released |

## Verification
The bench builds the block with CNT_W = 5, so the count saturates at 31. This makes the full-scale interval of R9 short enough to run edge by edge. The bench measures every phase boundary against the stated two- and three-edge synchronizer latency. It changes `delay_count` in mid-interval to show that the captured value rules. It also aborts an interval part-way, then confirms that the next wake-up starts again from a cleared count.

// File: rtl/cp_seq_pkg.sv
// Package: shared types for the charge-pump wake-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package cp_seq_pkg;
    // Phase of the wake-up sequence.
    typedef enum logic [1:0] {
        PH_SLEEP = 2'd0,
        PH_BOOST = 2'd1,
        PH_RUN   = 2'd2
    } phase_t;
endpackage

// File: rtl/cp_seq_sync.sv
// Module: multi-flop level synchronizer.
// Brings an asynchronous level into the clk domain through STAGES flops.
// Assumes: STAGES >= 2; the input is a slow level, not a pulse.
module cp_seq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_a,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d_a};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cp_seq_counter.sv
// Module: boost-interval counter.
// Counts reference cycles while run is high and flags the final cycle of
// a target-long interval.
// Assumes: target >= 1 whenever run is high; clear wins over run.
module cp_seq_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] target,
    output logic         last
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    // Advance the count during the interval; zero it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (run)        cnt <= cnt + ONE;
    end

    // Last cycle of the interval: target-1 cycles have already elapsed.
    always_comb begin
        last = run && (cnt == (target - ONE));
    end
endmodule

// File: rtl/cp_seq_ctrl.sv
// Module: wake-up phase controller.
// Walks sleep -> boost -> run. It captures the programmed interval on leaving
// sleep and gates every pump output with the synchronized standby level,
// so a standby request takes effect without waiting for a state change.
// Assumes: stby is already synchronous to clk.
module cp_seq_ctrl
    import cp_seq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stby,
    input  logic [W-1:0] delay_in,
    input  logic         cnt_last,
    output logic [W-1:0] target,
    output logic         cnt_clear,
    output logic         cnt_run,
    output logic         main_en,
    output logic         aux_off,
    output logic         done
);
    phase_t phase, phase_nx;

    // Next-phase decision.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_SLEEP: if (!stby) phase_nx = (delay_in == '0) ? PH_RUN : PH_BOOST;
            PH_BOOST: if (stby) phase_nx = PH_SLEEP;
                      else if (cnt_last) phase_nx = PH_RUN;
            PH_RUN:   if (stby) phase_nx = PH_SLEEP;
            default:  phase_nx = PH_SLEEP;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_SLEEP;
        else        phase <= phase_nx;
    end

    // Capture the interval length at the moment the sequence starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                           target <= '0;
        else if (phase == PH_SLEEP && !stby)  target <= delay_in;
    end

    // Counter control: count only in boost, hold cleared elsewhere.
    always_comb begin
        cnt_run   = (phase == PH_BOOST) && !stby;
        cnt_clear = (phase != PH_BOOST) || stby;
    end

    // Pump controls, forced idle by standby.
    always_comb begin
        main_en = (phase != PH_SLEEP) && !stby;
        aux_off = (phase != PH_RUN)   || stby;
        done    = (phase == PH_RUN)   && !stby;
    end
endmodule

// File: rtl/cp_wake_sequencer.sv
// Module: charge-pump wake-up sequencer (top).
// Synchronizes standby, then runs the main pump alone for a programmed
// number of reference cycles before releasing the opposing auxiliary pump.
// Assumes: clk is the synthesizer reference clock.
module cp_wake_sequencer #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_a,
    input  logic [CNT_W-1:0] delay_count,
    output logic             main_pump_en,
    output logic             aux_pump_off,
    output logic             settle_done
);
    logic             stby_s;
    logic [CNT_W-1:0] target;
    logic             cnt_clear;
    logic             cnt_run;
    logic             cnt_last;

    cp_seq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_a   (standby_a),
        .q     (stby_s)
    );

    cp_seq_counter #(.W(CNT_W)) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .run    (cnt_run),
        .target (target),
        .last   (cnt_last)
    );

    cp_seq_ctrl #(.W(CNT_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .stby      (stby_s),
        .delay_in  (delay_count),
        .cnt_last  (cnt_last),
        .target    (target),
        .cnt_clear (cnt_clear),
        .cnt_run   (cnt_run),
        .main_en   (main_pump_en),
        .aux_off   (aux_pump_off),
        .done      (settle_done)
    );
endmodule

// File: rtl/cp_wake_sequencer_chk.sv
// Module: assertion checker for the wake-up sequencer, bound to the top.
// Assumes: default synchronizer depth of two stages.
module cp_wake_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic standby_a,
    input logic main_pump_en,
    input logic aux_pump_off,
    input logic settle_done
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!main_pump_en && aux_pump_off && !settle_done)); // R1

    AST_AUX_NEEDS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_pump_off |-> main_pump_en); // R3

    AST_DONE_BOTH_ON: assert property (@(posedge clk) disable iff (!rst_n)
        settle_done |-> (main_pump_en && !aux_pump_off)); // R6

    AST_DONE_FALLS_ON_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(settle_done) |-> $past(standby_a, 2)); // R6

    AST_STANDBY_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(standby_a, 2) |-> (!main_pump_en && aux_pump_off)); // R7
endmodule

bind cp_wake_sequencer cp_wake_sequencer_chk i_chk (.*);

// File: tb/test_cp_wake_sequencer.sv
module test_cp_wake_sequencer;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         standby_a = 1'b1;
    logic [W-1:0] delay_count = '0;
    logic         main_pump_en, aux_pump_off, settle_done;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cp_wake_sequencer #(.CNT_W(W)) i_cp_wake_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby_a    (standby_a),
        .delay_count  (delay_count),
        .main_pump_en (main_pump_en),
        .aux_pump_off (aux_pump_off),
        .settle_done  (settle_done)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string req, input logic m, input logic a, input logic d);
        chk(req, "main_pump_en", main_pump_en, m);
        chk(req, "aux_pump_off", aux_pump_off, a);
        chk(req, "settle_done", settle_done, d);
    endtask

    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Put the block to sleep and let the synchronizer settle.
    task automatic go_sleep();
        @(negedge clk);
        standby_a = 1'b1;
        for (int i = 0; i < 4; i++) edge_step();
        chk_all("R7", 1'b0, 1'b1, 1'b0);
    endtask

    // Wake with count n; optional count change after edge chg_at.
    // Main pump on after edge 3, auxiliary released after edge 3+n.
    task automatic wake_seq(input int n, input int chg_at, input int new_val, input string req);
        @(negedge clk);
        standby_a = 1'b0;
        delay_count = W'(n);
        for (int e = 1; e <= n + 5; e++) begin
            edge_step();
            if (e == chg_at) delay_count = W'(new_val);
            chk_all(req, (e >= 3), !(e >= 3 + n), (e >= 3 + n));
        end
    endtask

    task automatic t_reset();
        standby_a = 1'b0;
        delay_count = W'(4);
        for (int i = 0; i < 3; i++) begin
            edge_step();
            chk_all("R1", 1'b0, 1'b1, 1'b0);
        end
        rst_n = 1'b1;
        for (int e = 1; e <= 9; e++) begin
            edge_step();
            chk_all("R2", (e >= 3), !(e >= 7), (e >= 7));
        end
    endtask

    task automatic t_sleep_latency();
        @(negedge clk);
        standby_a = 1'b1;
        edge_step();
        chk_all("R2", 1'b1, 1'b0, 1'b1);
        edge_step();
        chk_all("R2", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_done_hold();
        for (int i = 0; i < 20; i++) begin
            edge_step();
            chk_all("R6", 1'b1, 1'b0, 1'b1);
        end
    endtask

    task automatic t_abort();
        @(negedge clk);
        standby_a = 1'b0;
        delay_count = W'(10);
        for (int e = 1; e <= 6; e++) begin
            edge_step();
            chk_all("R7", (e >= 3), 1'b1, 1'b0);
        end
        standby_a = 1'b1;
        edge_step();
        chk_all("R7", 1'b1, 1'b1, 1'b0);
        edge_step();
        chk_all("R7", 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) edge_step();
        wake_seq(10, 0, 0, "R7");
    endtask

    initial begin
        t_reset();
        t_sleep_latency();
        go_sleep();
        wake_seq(5, 0, 0, "R4");
        t_done_hold();
        go_sleep();
        wake_seq(1, 0, 0, "R3");
        go_sleep();
        wake_seq(0, 0, 0, "R5");
        go_sleep();
        wake_seq(6, 4, 1, "R8");
        go_sleep();
        t_abort();
        go_sleep();
        wake_seq(31, 0, 0, "R9");
        go_sleep();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule